// File: doc/BRIEF.md
# Shared-Timer GPIO Input Debouncer

This block cleans up a group of general-purpose input pins before the rest of the chip sees them. Each pin first passes through a two-flop synchronizer. It is then either passed straight through, or held back by a stability filter. The filter moves the pin's output to a new level only after the synchronized input has stayed at that level for a programmed number of clock cycles.

The filter periods are not stored per pin. Three period registers are shared by the whole group. Each pin picks one of them, or picks bypass, with a 2-bit code. The two bits of that code sit in two separate select registers, at the pin's own bit position. The register at the lower address carries the upper code bit, and the register four bytes above it carries the lower code bit. Pins that cannot act as inputs never take a filter setting.

Software writes and reads the registers through a plain single-cycle register port. The filtered levels appear on `pin_filt`.

Top module: `gpio_debounce_filter`

## Requirements
- R1: While reset is asserted and at the first cycle after it, `pin_filt` is all zero, and every register reads back zero.
- R2: The three period registers sit at byte addresses 0x50, 0x54 and 0x58. Each is written in full (32 bits) with `reg_wr` and reads back the written value on `reg_rdata` for the address on `reg_raddr`.
- R3: The select register at 0x40 holds bit 1 of each pin's code, and the one at 0x44 holds bit 0, with pin n at bit n. Code 1 uses the period at 0x50, code 2 uses the one at 0x54, and code 3 uses the one at 0x58.
- R4: A pin whose code is 0 is in bypass. Its `pin_filt` bit takes a new `pin_raw` level at the third rising edge after that level is applied.
- R5: A pin with code 1 to 3 and period P ≥ 1 changes its output at the (2+P)-th rising edge after a new raw level is applied and held, and not earlier.
- R6: Any return of the synchronized input to the current output level clears the pin's count. A later change must again be held for the full period.
- R7: A period of 0 or 1 gives the same latency as bypass (three edges).
- R8: A period register write does not alter a count already started. The count uses the period seen at its first cycle, and later counts use the new value.
- R9: Pins cleared in parameter `IN_MASK` ignore writes to both select registers. Their select bits read back zero, and they stay in bypass.
- R10: Writes to addresses other than the five registers change no register, and reads of such addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 8 | Write byte address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 8 | Read byte address |
| reg_rdata | output | 32 | Read data (combinational) |
| pin_raw | input | 32 | Unsynchronized pin inputs |
| pin_filt | output | 32 | Filtered pin levels |

## Verification
The bench builds the block with all 32 pins and an `IN_MASK` that marks pin 31 as output-only. This brings the ignored-select behaviour of R9 within reach of the ports, while pins 0 to 3 cover every code value. The periods used are 5, 10 and 20 cycles, which separate the three timers' update edges clearly. Zero and one exercise the pass-through corner, and 8 changed to 2 in the middle of a count exercises the period latching.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;

  typedef enum logic [1:0] {
    DB_BYPASS = 2'd0,
    DB_TMR_A  = 2'd1,
    DB_TMR_B  = 2'd2,
    DB_TMR_C  = 2'd3
  } dbnc_code_e;

  // Upper code bit comes from the lower-addressed select register.
  function automatic dbnc_code_e pin_code(input logic upper_bit, input logic lower_bit);
    return dbnc_code_e'({upper_bit, lower_bit});
  endfunction

endpackage

// File: rtl/dbnc_regs.sv
module dbnc_regs #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_TMR  = 3,
  parameter logic [NUM_PINS-1:0] IN_MASK = '1,
  parameter logic [ADDR_W-1:0] SEL_BASE = 8'h40,
  parameter logic [ADDR_W-1:0] TMR_BASE = 8'h50
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               waddr,
  input  logic [DATA_W-1:0]               wdata,
  input  logic [ADDR_W-1:0]               raddr,
  output logic [DATA_W-1:0]               rdata,
  output logic [NUM_TMR-1:0][DATA_W-1:0]  tmr_period,
  output logic [NUM_PINS-1:0]             sel_upper,
  output logic [NUM_PINS-1:0]             sel_lower
);

  localparam int unsigned STRIDE = 4;
  localparam logic [ADDR_W-1:0] SEL_UP_ADDR = SEL_BASE;
  localparam logic [ADDR_W-1:0] SEL_LO_ADDR = SEL_BASE + ADDR_W'(STRIDE);

  function automatic logic [ADDR_W-1:0] tmr_addr(input int unsigned idx);
    return TMR_BASE + ADDR_W'(idx * STRIDE);
  endfunction

  logic [NUM_PINS-1:0] wmask_pins;
  assign wmask_pins = wdata[NUM_PINS-1:0] & IN_MASK;

  genvar t;
  generate
    for (t = 0; t < NUM_TMR; t++) begin : g_tmr
      logic hit;
      assign hit = wr_en && (waddr == tmr_addr(t));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   tmr_period[t] <= '0;
        else if (hit) tmr_period[t] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_upper <= '0;
      sel_lower <= '0;
    end else if (wr_en) begin
      if (waddr == SEL_UP_ADDR) sel_upper <= wmask_pins;
      if (waddr == SEL_LO_ADDR) sel_lower <= wmask_pins;
    end
  end

  always_comb begin
    rdata = '0;
    if (raddr == SEL_UP_ADDR) rdata[NUM_PINS-1:0] = sel_upper;
    if (raddr == SEL_LO_ADDR) rdata[NUM_PINS-1:0] = sel_lower;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (raddr == tmr_addr(i)) rdata = tmr_period[i];
    end
  end

endmodule

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/dbnc_pin_filter.sv
module dbnc_pin_filter
  import dbnc_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_TMR = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           sync_in,
  input  dbnc_code_e                     code,
  input  logic [NUM_TMR-1:0][DATA_W-1:0] tmr_period,
  output logic                           filt_q,
  output logic                           upd_evt
);

  logic [DATA_W-1:0] cnt_q, held_q, live_per, eff_per;
  logic mismatch, done;

  // True once the count including this cycle reaches the period.
  function automatic logic count_done(input logic [DATA_W-1:0] cnt,
                                      input logic [DATA_W-1:0] per);
    return ({1'b0, cnt} + (DATA_W+1)'(1)) >= {1'b0, per};
  endfunction

  always_comb begin
    unique case (code)
      DB_TMR_A: live_per = tmr_period[0];
      DB_TMR_B: live_per = tmr_period[1];
      DB_TMR_C: live_per = tmr_period[2];
      default:  live_per = '0;
    endcase
  end

  assign eff_per  = (cnt_q == '0) ? live_per : held_q;
  assign mismatch = sync_in != filt_q;
  assign done     = (code == DB_BYPASS) || count_done(cnt_q, eff_per);
  assign upd_evt  = mismatch && done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
      held_q <= '0;
    end else begin
      if (cnt_q == '0) held_q <= live_per;
      if (!mismatch) begin
        cnt_q <= '0;
      end else if (done) begin
        filt_q <= sync_in;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + DATA_W'(1);
      end
    end
  end

endmodule

// File: rtl/gpio_debounce_filter.sv
module gpio_debounce_filter
  import dbnc_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter logic [NUM_PINS-1:0] IN_MASK = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_waddr,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic [ADDR_W-1:0]   reg_raddr,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] pin_raw,
  output logic [NUM_PINS-1:0] pin_filt
);

  localparam int unsigned NUM_TMR = 3;

  logic [NUM_TMR-1:0][DATA_W-1:0] tmr_period;
  logic [NUM_PINS-1:0] sel_upper, sel_lower, sync_q, upd_vec, bypass_vec;

  dbnc_regs #(
    .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .NUM_TMR(NUM_TMR), .IN_MASK(IN_MASK)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .waddr(reg_waddr),
    .wdata(reg_wdata), .raddr(reg_raddr), .rdata(reg_rdata),
    .tmr_period(tmr_period), .sel_upper(sel_upper), .sel_lower(sel_lower)
  );

  dbnc_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(sync_q)
  );

  genvar p;
  generate
    for (p = 0; p < NUM_PINS; p++) begin : g_pin
      dbnc_code_e code;
      assign code          = pin_code(sel_upper[p], sel_lower[p]);
      assign bypass_vec[p] = (code == DB_BYPASS);
      dbnc_pin_filter #(.DATA_W(DATA_W), .NUM_TMR(NUM_TMR)) u_filt (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_q[p]), .code(code),
        .tmr_period(tmr_period), .filt_q(pin_filt[p]), .upd_evt(upd_vec[p])
      );
    end
  endgenerate

endmodule

// File: rtl/dbnc_checker.sv
module dbnc_checker #(
  parameter int unsigned NUM_PINS = 32,
  parameter logic [NUM_PINS-1:0] IN_MASK = '1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] sync_q,
  input logic [NUM_PINS-1:0] pin_filt,
  input logic [NUM_PINS-1:0] upd_vec,
  input logic [NUM_PINS-1:0] bypass_vec,
  input logic [NUM_PINS-1:0] sel_upper,
  input logic [NUM_PINS-1:0] sel_lower
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> pin_filt == '0); // R1
  AST_BYPASS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((pin_filt ^ $past(sync_q)) & $past(bypass_vec)) == '0); // R4
  AST_CHANGE_TOWARD_SYNC: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((pin_filt ^ $past(pin_filt)) & (pin_filt ^ $past(sync_q))) == '0); // R5
  AST_ONLY_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (pin_filt ^ $past(pin_filt)) == $past(upd_vec)); // R6
  AST_SEL_MASKED: assert property (@(posedge clk) disable iff (!rst_n) ((sel_upper | sel_lower) & ~IN_MASK) == '0); // R9

endmodule

bind gpio_debounce_filter dbnc_checker #(.NUM_PINS(NUM_PINS), .IN_MASK(IN_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_q(sync_q), .pin_filt(pin_filt), .upd_vec(upd_vec),
  .bypass_vec(bypass_vec), .sel_upper(sel_upper), .sel_lower(sel_lower)
);

// File: tb/gpio_debounce_filter_test.sv
module gpio_debounce_filter_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MASK = 32'h7FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [7:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pin_raw = '0;
  logic [31:0] pin_filt;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_debounce_filter #(.IN_MASK(MASK)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .pin_raw(pin_raw), .pin_filt(pin_filt)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
    reg_raddr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic pin_check(input string tag, input int p, input logic exp);
    check(tag, {31'b0, pin_filt[p]}, {31'b0, exp});
  endtask

  task automatic t_reset();
    check("R1 filt after reset", pin_filt, 32'h0);
    rd_check("R1 timer A reset", 8'h50, 32'h0);
    rd_check("R1 select upper reset", 8'h40, 32'h0);
  endtask

  task automatic t_regs();
    wr(8'h50, 32'd5); wr(8'h54, 32'd10); wr(8'h58, 32'd20);
    rd_check("R2 timer A", 8'h50, 32'd5);
    rd_check("R2 timer B", 8'h54, 32'd10);
    rd_check("R2 timer C", 8'h58, 32'd20);
    wr(8'h60, 32'hDEAD_BEEF);
    rd_check("R10 unmapped read", 8'h60, 32'h0);
    rd_check("R10 timer A kept", 8'h50, 32'd5);
  endtask

  task automatic t_select();
    // pin0 code1, pin1 code2, pin2 code3, pin3 bypass
    wr(8'h40, 32'h6); wr(8'h44, 32'h5);
    rd_check("R3 select upper", 8'h40, 32'h6);
    rd_check("R3 select lower", 8'h44, 32'h5);
  endtask

  task automatic t_bypass();
    pin_raw[3] = 1'b1;
    tick(2); pin_check("R4 bypass before", 3, 1'b0);
    tick(1); pin_check("R4 bypass after", 3, 1'b1);
  endtask

  task automatic t_debounce();
    pin_raw[2:0] = 3'b111;
    tick(6); pin_check("R5 code1 early", 0, 1'b0);
    tick(1); pin_check("R5 R3 code1 at 7", 0, 1'b1);
             pin_check("R5 code2 early", 1, 1'b0);
    tick(4); pin_check("R5 code2 at 11", 1, 1'b0);
    tick(1); pin_check("R5 R3 code2 at 12", 1, 1'b1);
    tick(9); pin_check("R5 code3 at 21", 2, 1'b0);
    tick(1); pin_check("R5 R3 code3 at 22", 2, 1'b1);
  endtask

  task automatic t_restart();
    pin_raw[0] = 1'b0;
    tick(3);
    pin_raw[0] = 1'b1;
    tick(1);
    pin_raw[0] = 1'b0;
    tick(3); pin_check("R6 held during bounce", 0, 1'b1);
    tick(3); pin_check("R6 count restarted", 0, 1'b1);
    tick(1); pin_check("R6 update after full period", 0, 1'b0);
  endtask

  task automatic t_zero();
    wr(8'h50, 32'd0);
    pin_raw[0] = 1'b1;
    tick(2); pin_check("R7 zero before", 0, 1'b0);
    tick(1); pin_check("R7 zero pass", 0, 1'b1);
    wr(8'h50, 32'd1);
    pin_raw[0] = 1'b0;
    tick(2); pin_check("R7 one before", 0, 1'b1);
    tick(1); pin_check("R7 one pass", 0, 1'b0);
  endtask

  task automatic t_period_change();
    wr(8'h50, 32'd8);
    pin_raw[0] = 1'b1;
    tick(2);
    wr(8'h50, 32'd2);
    tick(6); pin_check("R8 old period kept", 0, 1'b0);
    tick(1); pin_check("R8 old period done", 0, 1'b1);
    pin_raw[0] = 1'b0;
    tick(3); pin_check("R8 new period early", 0, 1'b1);
    tick(1); pin_check("R8 new period used", 0, 1'b0);
  endtask

  task automatic t_non_input();
    wr(8'h40, 32'h8000_0006); wr(8'h44, 32'h8000_0005);
    rd_check("R9 upper masked", 8'h40, 32'h6);
    rd_check("R9 lower masked", 8'h44, 32'h5);
    pin_raw[31] = 1'b1;
    tick(2); pin_check("R9 pin31 before", 31, 1'b0);
    tick(1); pin_check("R9 pin31 bypass", 31, 1'b1);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(1);
    check("R1 filt first cycle", pin_filt, 32'h0);
    t_regs();
    t_select();
    t_bypass();
    t_debounce();
    t_restart();
    t_zero();
    t_period_change();
    t_non_input();
    tick(2);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

endmodule